// File: doc/BRIEF.md
# Strap-Selected RMII Pin Multiplexer

This block owns eight multi-function pads and two management pads. It picks one of three interface roles from two configuration straps. The strap levels are captured while power-on reset is held and are kept after reset is released. The roles are:

- General-purpose I/O, used together with the internal PHY. Each pad has its own output enable.
- A MAC-side RMII link to an external PHY.
- A PHY-side (reverse) RMII link to an external MAC.

The block drives the pad output values and output enables. It returns pad input levels to the GPIO core, the RMII receive path, the reference clock and the management interface.

In both RMII roles the data and control signals use the same physical pads. Only their meaning changes: a transmit enable pad on one side is a carrier/valid pad on the other. The management clock pad changes direction between the two RMII roles. A software select input can move a MAC-role device between the internal PHY and the RMII pads after reset. It has no effect once the straps have chosen the PHY role.

Top module: `rmii_pinmux`

## Requirements
- R1: The strap inputs are sampled on every clock edge while `rst_n` is low. After release the captured values are held, so later changes on the strap pins do not change `mode_o`.
- R2: `mode_o` encodes the role as follows:
  - 0 means internal PHY. This is chosen when the captured rmii_n strap is 1.
  - 1 means MAC-side RMII. This is chosen when rmii_n is 0 and phy_n is 1.
  - 2 means PHY-side reverse RMII. This is chosen when both straps are 0.
- R3: While `rst_n` is low, every pad output enable is 0: all eight `mfb_pad_oe_o` bits, `mdc_pad_oe_o` and `mdio_pad_oe_o`.
- R4: In mode 0, every multi-function pad `k` is GPIO: `mfb_pad_o[k]=gpio_out_i[k]` and `mfb_pad_oe_o[k]=gpio_oe_i[k]`. `gpio_in_o` always equals `mfb_pad_i`.
- R5: Pad bit 0 is GPIO in every mode, with its output value and enable taken from bit 0 of the GPIO inputs.
- R6: In modes 1 and 2 the data and control pads are assigned as follows:
  - Pads 2, 3 and 4 are enabled outputs carrying `rmii_tx_en_i`, `rmii_txd_i[1]` and `rmii_txd_i[0]`.
  - Pads 1, 6 and 7 are inputs with enable 0 and output value 0.
  - `rmii_rx_dv_o` is pad 1, and `rmii_rxd_o` is {pad 6, pad 7}.
  - In mode 0, `rmii_rx_dv_o` and `rmii_rxd_o` are 0.
- R7: In modes 1 and 2, pad 5 carries the reference clock, with its direction set by `refclk_out_en_i` and not by the mode:
  - Its enable equals `refclk_out_en_i` and its output value is `refclk_i`.
  - `refclk_o` is `refclk_i` when the pad is an output, and pad 5 otherwise.
  - In mode 0, `refclk_o` is 0.
- R8: The management clock pad depends on the mode:
  - In mode 1 it is an output with enable 1 and value `mdc_i`, and `mdc_o` is 0.
  - In mode 2 it is an input with enable 0, and `mdc_o` equals `mdc_pad_i`.
  - In mode 0 the enable, the output value and `mdc_o` are all 0.
- R9: In modes 1 and 2 the management data pad is bidirectional:
  - Its enable is `mdio_oe_i`, its output value is `mdio_out_i`, and `mdio_in_o` equals `mdio_pad_i`.
  - In mode 0 the enable and output value are 0, and `mdio_in_o` is 1.
- R10: When `sw_sel_en_i` is 1 and the captured straps select a MAC role, `mode_o` is 1 if `sw_sel_ext_i` is 1 and 0 otherwise. When the straps select the PHY role, both software inputs are ignored and `mode_o` stays 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset; straps are sampled while low |
| strap_rmii_n_i | input | 1 | Strap pin level: 0 requests an RMII role |
| strap_phy_n_i | input | 1 | Strap pin level: 0 requests the PHY role |
| sw_sel_en_i | input | 1 | Software select valid |
| sw_sel_ext_i | input | 1 | Software select value: 1 selects the RMII pads in a MAC role |
| mode_o | output | 2 | Active role (0 internal PHY, 1 MAC RMII, 2 reverse RMII) |
| gpio_out_i | input | 8 | GPIO output values |
| gpio_oe_i | input | 8 | GPIO output enables |
| gpio_in_o | output | 8 | Pad input levels to the GPIO core |
| rmii_tx_en_i | input | 1 | RMII transmit enable from the datapath |
| rmii_txd_i | input | 2 | RMII transmit data from the datapath |
| rmii_rx_dv_o | output | 1 | RMII receive carrier/valid to the datapath |
| rmii_rxd_o | output | 2 | RMII receive data to the datapath |
| refclk_i | input | 1 | Internally generated reference clock |
| refclk_out_en_i | input | 1 | Configuration flag: 1 drives the reference clock out |
| refclk_o | output | 1 | Reference clock seen by the RMII datapath |
| mdc_i | input | 1 | Management clock from the internal master |
| mdc_o | output | 1 | Management clock received in the reverse role |
| mdio_out_i | input | 1 | Management data output value |
| mdio_oe_i | input | 1 | Management data output enable |
| mdio_in_o | output | 1 | Management data input level |
| mfb_pad_i | input | 8 | Multi-function pad input levels |
| mfb_pad_o | output | 8 | Multi-function pad output values |
| mfb_pad_oe_o | output | 8 | Multi-function pad output enables |
| mdc_pad_i | input | 1 | Management clock pad input level |
| mdc_pad_o | output | 1 | Management clock pad output value |
| mdc_pad_oe_o | output | 1 | Management clock pad output enable |
| mdio_pad_i | input | 1 | Management data pad input level |
| mdio_pad_o | output | 1 | Management data pad output value |
| mdio_pad_oe_o | output | 1 | Management data pad output enable |

## Verification
The bench goes after four kinds of error:

- **Straps not held after reset.** The strap pins are changed after reset is released. A design that kept tracking them would switch roles in the middle of operation.
- **Wrong pad direction.** Each role is checked with random GPIO enables set to all ones. A design that let GPIO enables reach the RMII pads would fight the external device on its input pads. A design that drove the management clock in the reverse role would do the same.
- **Software select reaching the PHY role.** The select is toggled while the straps choose the PHY role. A design that obeyed it would turn the reverse link back into GPIO.
- **Enables active during reset.** All enables are held high while reset is asserted. Any pad enable that leaked through would corrupt the strap levels being sampled.

// File: rtl/rmii_pinmux.sv
module rmii_pinmux (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_rmii_n_i,
  input  logic       strap_phy_n_i,
  input  logic       sw_sel_en_i,
  input  logic       sw_sel_ext_i,
  output logic [1:0] mode_o,
  input  logic [7:0] gpio_out_i,
  input  logic [7:0] gpio_oe_i,
  output logic [7:0] gpio_in_o,
  input  logic       rmii_tx_en_i,
  input  logic [1:0] rmii_txd_i,
  output logic       rmii_rx_dv_o,
  output logic [1:0] rmii_rxd_o,
  input  logic       refclk_i,
  input  logic       refclk_out_en_i,
  output logic       refclk_o,
  input  logic       mdc_i,
  output logic       mdc_o,
  input  logic       mdio_out_i,
  input  logic       mdio_oe_i,
  output logic       mdio_in_o,
  input  logic [7:0] mfb_pad_i,
  output logic [7:0] mfb_pad_o,
  output logic [7:0] mfb_pad_oe_o,
  input  logic       mdc_pad_i,
  output logic       mdc_pad_o,
  output logic       mdc_pad_oe_o,
  input  logic       mdio_pad_i,
  output logic       mdio_pad_o,
  output logic       mdio_pad_oe_o
);
  localparam logic [1:0] MODE_INT = 2'd0;
  localparam logic [1:0] MODE_MAC = 2'd1;
  localparam logic [1:0] MODE_PHY = 2'd2;

  localparam int unsigned P_RXDV  = 1;
  localparam int unsigned P_TXEN  = 2;
  localparam int unsigned P_TXD1  = 3;
  localparam int unsigned P_TXD0  = 4;
  localparam int unsigned P_REF   = 5;
  localparam int unsigned P_RXD1  = 6;
  localparam int unsigned P_RXD0  = 7;

  logic       rmii_n_q, phy_n_q;
  logic [1:0] strap_mode;
  logic       link_on;
  logic [7:0] oe_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rmii_n_q <= strap_rmii_n_i;
      phy_n_q  <= strap_phy_n_i;
    end
  end

  assign strap_mode = rmii_n_q ? MODE_INT : (phy_n_q ? MODE_MAC : MODE_PHY);

  assign mode_o = (strap_mode != MODE_PHY && sw_sel_en_i)
                ? (sw_sel_ext_i ? MODE_MAC : MODE_INT)
                : strap_mode;

  assign link_on   = (mode_o != MODE_INT);
  assign gpio_in_o = mfb_pad_i;

  always_comb begin
    mfb_pad_o = gpio_out_i;
    oe_raw    = gpio_oe_i;
    if (link_on) begin
      mfb_pad_o[P_RXDV] = 1'b0;
      oe_raw[P_RXDV]    = 1'b0;
      mfb_pad_o[P_RXD1] = 1'b0;
      oe_raw[P_RXD1]    = 1'b0;
      mfb_pad_o[P_RXD0] = 1'b0;
      oe_raw[P_RXD0]    = 1'b0;
      mfb_pad_o[P_TXEN] = rmii_tx_en_i;
      oe_raw[P_TXEN]    = 1'b1;
      mfb_pad_o[P_TXD1] = rmii_txd_i[1];
      oe_raw[P_TXD1]    = 1'b1;
      mfb_pad_o[P_TXD0] = rmii_txd_i[0];
      oe_raw[P_TXD0]    = 1'b1;
      mfb_pad_o[P_REF]  = refclk_i;
      oe_raw[P_REF]     = refclk_out_en_i;
    end
  end

  assign mfb_pad_oe_o = rst_n ? oe_raw : 8'h00;

  assign rmii_rx_dv_o = link_on & mfb_pad_i[P_RXDV];
  assign rmii_rxd_o   = link_on ? {mfb_pad_i[P_RXD1], mfb_pad_i[P_RXD0]} : 2'b00;
  assign refclk_o     = link_on & (refclk_out_en_i ? refclk_i : mfb_pad_i[P_REF]);

  assign mdc_pad_o     = (mode_o == MODE_MAC) & mdc_i;
  assign mdc_pad_oe_o  = rst_n & (mode_o == MODE_MAC);
  assign mdc_o         = (mode_o == MODE_PHY) & mdc_pad_i;

  assign mdio_pad_o    = link_on & mdio_out_i;
  assign mdio_pad_oe_o = rst_n & link_on & mdio_oe_i;
  assign mdio_in_o     = link_on ? mdio_pad_i : 1'b1;
endmodule

module rmii_pinmux_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode_o,
  input logic       sw_sel_en_i,
  input logic       sw_sel_ext_i,
  input logic [7:0] gpio_oe_i,
  input logic [7:0] mfb_pad_oe_o,
  input logic       mdc_pad_oe_o,
  input logic       mdio_pad_oe_o
);
  a_r3_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (mfb_pad_oe_o == 8'h00 && !mdc_pad_oe_o && !mdio_pad_oe_o));

  a_r1_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $stable(sw_sel_en_i) && $stable(sw_sel_ext_i)) |-> $stable(mode_o));

  a_r10_phy_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> (mode_o == 2'd2));

  a_r6_link_dirs: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd0) |-> (mfb_pad_oe_o[4:1] == 4'b1110 && mfb_pad_oe_o[7:6] == 2'b00));

  a_r5_bit0_gpio: assert property (@(posedge clk) disable iff (!rst_n)
    mfb_pad_oe_o[0] == gpio_oe_i[0]);

  a_r8_mdc_dir: assert property (@(posedge clk) disable iff (!rst_n)
    mdc_pad_oe_o == (mode_o == 2'd1));
endmodule

bind rmii_pinmux rmii_pinmux_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode_o(mode_o),
  .sw_sel_en_i(sw_sel_en_i), .sw_sel_ext_i(sw_sel_ext_i),
  .gpio_oe_i(gpio_oe_i), .mfb_pad_oe_o(mfb_pad_oe_o),
  .mdc_pad_oe_o(mdc_pad_oe_o), .mdio_pad_oe_o(mdio_pad_oe_o)
);

// File: tb/rmii_pinmux_tb.sv
module rmii_pinmux_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_rmii_n_i = 1'b1, strap_phy_n_i = 1'b1;
  logic sw_sel_en_i = 1'b0, sw_sel_ext_i = 1'b0;
  logic [1:0] mode_o;
  logic [7:0] gpio_out_i = '0, gpio_oe_i = '0, gpio_in_o;
  logic rmii_tx_en_i = 1'b0;
  logic [1:0] rmii_txd_i = '0;
  logic rmii_rx_dv_o;
  logic [1:0] rmii_rxd_o;
  logic refclk_i = 1'b0, refclk_out_en_i = 1'b0, refclk_o;
  logic mdc_i = 1'b0, mdc_o;
  logic mdio_out_i = 1'b0, mdio_oe_i = 1'b0, mdio_in_o;
  logic [7:0] mfb_pad_i = '0, mfb_pad_o, mfb_pad_oe_o;
  logic mdc_pad_i = 1'b0, mdc_pad_o, mdc_pad_oe_o;
  logic mdio_pad_i = 1'b0, mdio_pad_o, mdio_pad_oe_o;

  int n_tests = 0;
  int n_fail  = 0;
  logic cap_rmii_n, cap_phy_n;

  always #10 clk = ~clk;

  rmii_pinmux dut_i (.*);

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] exp_mode(input logic rn, input logic pn, input logic en, input logic ext);
    logic [1:0] s;
    s = rn ? 2'd0 : (pn ? 2'd1 : 2'd2);
    if (s != 2'd2 && en) s = ext ? 2'd1 : 2'd0;
    return s;
  endfunction

  task automatic check_outputs();
    logic [1:0] m;
    logic lk;
    m  = exp_mode(cap_rmii_n, cap_phy_n, sw_sel_en_i, sw_sel_ext_i);
    lk = (m != 2'd0);
    check("R2/R10 mode", {6'd0, mode_o}, {6'd0, m});
    check("R4 gpio_in", gpio_in_o, mfb_pad_i);
    if (!lk) begin
      check("R4 pad_o", mfb_pad_o, gpio_out_i);
      check("R4 pad_oe", mfb_pad_oe_o, gpio_oe_i);
    end else begin
      check("R6 pad_oe", mfb_pad_oe_o[7:1], {2'b00, refclk_out_en_i, 4'b1110});
      check("R6 pad_o", {mfb_pad_o[7:6], mfb_pad_o[4:1]},
            {2'b00, rmii_txd_i[0], rmii_txd_i[1], rmii_tx_en_i, 1'b0});
      check("R7 ref pad_o", {7'd0, mfb_pad_o[5]}, {7'd0, refclk_i});
    end
    check("R5 bit0", {6'd0, mfb_pad_o[0], mfb_pad_oe_o[0]}, {6'd0, gpio_out_i[0], gpio_oe_i[0]});
    check("R6 rx", {5'd0, rmii_rx_dv_o, rmii_rxd_o},
          lk ? {5'd0, mfb_pad_i[1], mfb_pad_i[6], mfb_pad_i[7]} : 8'd0);
    check("R7 refclk_o", {7'd0, refclk_o},
          {7'd0, lk & (refclk_out_en_i ? refclk_i : mfb_pad_i[5])});
    check("R8 mdc", {5'd0, mdc_pad_oe_o, mdc_pad_o, mdc_o},
          {5'd0, m == 2'd1, (m == 2'd1) & mdc_i, (m == 2'd2) & mdc_pad_i});
    check("R9 mdio", {5'd0, mdio_pad_oe_o, mdio_pad_o, mdio_in_o},
          {5'd0, lk & mdio_oe_i, lk & mdio_out_i, lk ? mdio_pad_i : 1'b1});
  endtask

  task automatic randomize_inputs(input int sw_pct);
    gpio_out_i = 8'($urandom); gpio_oe_i = 8'($urandom);
    rmii_tx_en_i = 1'($urandom); rmii_txd_i = 2'($urandom);
    refclk_i = 1'($urandom); refclk_out_en_i = 1'($urandom);
    mdc_i = 1'($urandom); mdio_out_i = 1'($urandom); mdio_oe_i = 1'($urandom);
    mfb_pad_i = 8'($urandom); mdc_pad_i = 1'($urandom); mdio_pad_i = 1'($urandom);
    sw_sel_en_i = (($urandom % 100) < sw_pct); sw_sel_ext_i = 1'($urandom);
  endtask

  task automatic do_reset(input logic rn, input logic pn);
    @(negedge clk);
    rst_n = 1'b0;
    strap_rmii_n_i = rn; strap_phy_n_i = pn;
    gpio_oe_i = 8'hFF; refclk_out_en_i = 1'b1; mdio_oe_i = 1'b1; sw_sel_en_i = 1'b0;
    repeat (3) @(negedge clk);
    #2;
    check("R3 oe in reset", mfb_pad_oe_o, 8'h00);
    check("R3 mgmt oe in reset", {6'd0, mdc_pad_oe_o, mdio_pad_oe_o}, 8'h00);
    cap_rmii_n = rn; cap_phy_n = pn;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int c = 0; c < 4; c++) begin
      do_reset(c[1], c[0]);
      @(negedge clk); #2;
      check_outputs();
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        randomize_inputs(30);
        #2;
        check_outputs();
      end
      // R1: strap pins change after release, mode must not follow
      @(negedge clk);
      sw_sel_en_i = 1'b0;
      strap_rmii_n_i = ~c[1]; strap_phy_n_i = ~c[0];
      repeat (3) @(negedge clk);
      #2;
      check("R1 straps held", {6'd0, mode_o}, {6'd0, exp_mode(c[1], c[0], 1'b0, 1'b0)});
      // R10: software select in both values
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        sw_sel_en_i = 1'b1; sw_sel_ext_i = s[0];
        gpio_oe_i = 8'hFF;
        #2;
        check("R10 sw select", {6'd0, mode_o}, {6'd0, exp_mode(c[1], c[0], 1'b1, s[0])});
        check_outputs();
      end
    end
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule